// File: doc/BRIEF.md
# Receive Sample Packet Accumulator

This block sits between a receive sample source and a 64-bit network framer. Complex samples are 32 bits wide and arrive on a slow strobe. Each one is written into an internal sample store. The framer sees nothing until a whole payload is stored. The payload is then released as an uninterrupted run of 64-bit beats at the framer's pace, and each beat carries two samples.

The store holds several payloads, so one payload can fill while the previous one drains. When the store is full, an arriving sample is discarded and not allowed to stall the source. Later samples therefore keep their place in time. A sticky flag and a counter record how many samples were discarded, and a clear input resets both. A single clock serves both sides: the sample strobe plays the role of the slow domain.

Top module: `rx_pkt_accum`

## Requirements
- R1: After reset, m_valid, ovf_flag and drop_cnt are all zero.
- R2: Each cycle with s_valid high stores s_data as the next sample when the store holds fewer than FIFO_PAYLOADS*2*PAYLOAD_BEATS samples.
- R3: m_valid stays low until 2*PAYLOAD_BEATS samples are stored; it rises one cycle after the store reaches that count.
- R4: In each beat, the earlier sample sits in m_data[31:0] and the later one in m_data[63:32].
- R5: A payload is exactly PAYLOAD_BEATS beats. m_sop is high only on its first beat and m_eop only on its last beat. Samples come out in arrival order.
- R6: While m_valid is high and m_ready is low, m_valid, m_data, m_sop and m_eop hold their values on the next cycle.
- R7: A sample that arrives when the store is full is dropped. Samples accepted later are delivered in order, with no gap filled in.
- R8: Each dropped sample sets ovf_flag and increments drop_cnt, which saturates. A cycle with ovf_clr high zeroes both, and a drop in that same cycle is not counted.
- R9: Samples keep being accepted while a payload drains, so a payload can fill during the drain of another.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| s_valid | input | 1 | Sample strobe |
| s_data | input | SAMPLE_W | Complex sample |
| m_ready | input | 1 | Framer accepts the current beat |
| m_valid | output | 1 | Beat available |
| m_data | output | 2*SAMPLE_W | Two packed samples |
| m_sop | output | 1 | First beat of a payload |
| m_eop | output | 1 | Last beat of a payload |
| ovf_clr | input | 1 | Clears ovf_flag and drop_cnt |
| ovf_flag | output | 1 | Sticky drop indicator |
| drop_cnt | output | CNT_W | Number of dropped samples |

## Verification
The hardest situation to reach is a full store: the source must outrun the drain, and samples must be dropped while beats are pending. The bench holds m_ready low and pushes more than two payloads of consecutive sample values. The missing values then appear directly in the drained data and in the counter. It repeats the overrun with the clear asserted in the same cycle as a drop, and closes with a long run where filling and random backpressure overlap.

// File: rtl/rx_pkt_accum.sv
module rx_pkt_accum #(
  parameter int SAMPLE_W      = 32,
  parameter int PAYLOAD_BEATS = 200,
  parameter int FIFO_PAYLOADS = 2,
  parameter int CNT_W         = 16
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  s_valid,
  input  logic [SAMPLE_W-1:0]   s_data,
  input  logic                  m_ready,
  output logic                  m_valid,
  output logic [2*SAMPLE_W-1:0] m_data,
  output logic                  m_sop,
  output logic                  m_eop,
  input  logic                  ovf_clr,
  output logic                  ovf_flag,
  output logic [CNT_W-1:0]      drop_cnt
);
  localparam int PAY_SMP = 2 * PAYLOAD_BEATS;
  localparam int DEPTH   = FIFO_PAYLOADS * PAY_SMP;
  localparam int AW      = $clog2(DEPTH);
  localparam int LW      = $clog2(DEPTH + 1);
  localparam int BW      = $clog2(PAYLOAD_BEATS + 1);

  logic [SAMPLE_W-1:0] mem [DEPTH];
  logic [AW-1:0] wr_ptr, rd_ptr;
  logic [LW-1:0] level;
  logic [BW-1:0] beat;
  logic          busy;

  wire wr_ok   = s_valid && (level < LW'(DEPTH));
  wire drop    = s_valid && !wr_ok;
  wire rd_fire = busy && m_ready;
  wire last    = (beat == BW'(PAYLOAD_BEATS - 1));

  assign m_valid = busy;
  assign m_data  = {mem[rd_ptr + AW'(1)], mem[rd_ptr]};
  assign m_sop   = busy && (beat == '0);
  assign m_eop   = busy && last;

  always_ff @(posedge clk)
    if (wr_ok) mem[wr_ptr] <= s_data;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      level  <= '0;
      beat   <= '0;
      busy   <= 1'b0;
    end else begin
      if (wr_ok) wr_ptr <= (wr_ptr == AW'(DEPTH - 1)) ? '0 : wr_ptr + AW'(1);
      if (rd_fire) rd_ptr <= (rd_ptr == AW'(DEPTH - 2)) ? '0 : rd_ptr + AW'(2);
      level <= level + LW'(wr_ok) - (rd_fire ? LW'(2) : LW'(0));
      if (!busy) begin
        beat <= '0;
        if (level >= LW'(PAY_SMP)) busy <= 1'b1;
      end else if (rd_fire) begin
        beat <= last ? '0 : beat + BW'(1);
        if (last) busy <= 1'b0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || ovf_clr) begin
      ovf_flag <= 1'b0;
      drop_cnt <= '0;
    end else if (drop) begin
      ovf_flag <= 1'b1;
      if (drop_cnt != '1) drop_cnt <= drop_cnt + CNT_W'(1);
    end
  end
endmodule

module rx_pkt_accum_chk #(
  parameter int SAMPLE_W = 32,
  parameter int CNT_W    = 16
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic                  m_ready,
  input logic                  m_valid,
  input logic [2*SAMPLE_W-1:0] m_data,
  input logic                  m_sop,
  input logic                  m_eop,
  input logic                  ovf_clr,
  input logic                  ovf_flag,
  input logic [CNT_W-1:0]      drop_cnt
);
  // R6
  hold_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && !m_ready |=> m_valid && $stable(m_data) && $stable(m_sop) && $stable(m_eop));
  // R5
  sop_needs_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (m_sop || m_eop) |-> m_valid);
  // R5
  sop_after_eop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    m_valid && m_ready && !m_eop |=> m_valid && !m_sop);
  // R8
  sticky_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_flag && !ovf_clr |=> ovf_flag);
  // R8
  cnt_monotone_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ovf_clr |=> drop_cnt >= $past(drop_cnt));
  // R8
  clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_clr |=> !ovf_flag && drop_cnt == '0);
  // R8
  cnt_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    drop_cnt != '0 |-> ovf_flag);
endmodule

bind rx_pkt_accum rx_pkt_accum_chk #(.SAMPLE_W(SAMPLE_W), .CNT_W(CNT_W)) u_chk (.*);

// File: tb/rx_pkt_accum_bench.sv
module rx_pkt_accum_bench;
  localparam int SW = 32, BEATS = 4, PAYS = 2, CW = 16;
  localparam int PAY = 2 * BEATS, DEPTH = PAYS * PAY;

  logic clk = 0, rst_n = 0, s_valid = 0, m_ready = 0, ovf_clr = 0;
  logic [SW-1:0] s_data = '0;
  logic m_valid, m_sop, m_eop, ovf_flag;
  logic [2*SW-1:0] m_data;
  logic [CW-1:0] drop_cnt;
  int vecs = 0, errs = 0;

  always #2.5 clk = ~clk;

  rx_pkt_accum #(.SAMPLE_W(SW), .PAYLOAD_BEATS(BEATS), .FIFO_PAYLOADS(PAYS), .CNT_W(CW)) u_rx_pkt_accum (.*);

  task automatic chk(input logic ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    vecs++;
    if (!ok) begin
      errs++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic report();
    $display("== %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  endtask

  task automatic send(input int n, input int base, input int gap);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); s_valid = 1; s_data = base + i;
      for (int g = 0; g < gap; g++) begin @(negedge clk); s_valid = 0; end
    end
    @(negedge clk); s_valid = 0;
  endtask

  task automatic drain(input int base, input bit rnd);
    int i = 0;
    logic held = 0;
    logic [63:0] hd;
    logic hs, he;
    while (i < BEATS) begin
      @(negedge clk);
      if (held) begin
        chk(m_valid && m_data == hd && m_sop == hs && m_eop == he, "R6 hold",
            {m_sop, m_eop, m_data[61:0]}, {hs, he, hd[61:0]});
        held = 0;
      end
      m_ready = rnd ? 1'($urandom % 2) : 1'b1;
      if (m_valid && m_ready) begin
        logic [63:0] e;
        e = {32'(base + 2*i + 1), 32'(base + 2*i)};
        chk(m_data == e, "R4/R5 data", m_data, e);
        chk(m_sop == (i == 0) && m_eop == (i == BEATS-1), "R5 sop/eop",
            {m_sop, m_eop}, {i == 0, i == BEATS-1});
        i++;
      end else if (m_valid) begin
        held = 1; hd = m_data; hs = m_sop; he = m_eop;
      end
    end
    @(negedge clk); m_ready = 0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errs++;
    $display("FAIL watchdog expired");
    report();
  end

  initial begin
    repeat (3) @(negedge clk);
    chk(!m_valid && !ovf_flag && drop_cnt == 0, "R1 reset", {m_valid, ovf_flag, drop_cnt}, 0);
    rst_n = 1;
    // R3: one short of a payload
    send(PAY - 1, 100, 0);
    repeat (5) @(negedge clk);
    chk(!m_valid, "R3 held back", m_valid, 0);
    send(1, 100 + PAY - 1, 0);
    chk(!m_valid, "R3 not before count registered", m_valid, 0);
    @(negedge clk);
    chk(m_valid && m_sop, "R3 release", {m_valid, m_sop}, 2'b11);
    drain(100, 0);
    // R6 random backpressure
    send(PAY, 200, 0);
    drain(200, 1);
    // R7 overrun
    send(DEPTH + 4, 300, 0);
    chk(drop_cnt == 4 && ovf_flag, "R8 count", {ovf_flag, drop_cnt}, {1'b1, 16'd4});
    drain(300, 0);
    drain(300 + PAY, 1);
    repeat (4) @(negedge clk);
    chk(!m_valid, "R7 dropped not delivered", m_valid, 0);
    send(PAY, 400, 0);
    drain(400, 0);
    chk(drop_cnt == 4, "R8 count held", drop_cnt, 4);
    // R8 clear
    @(negedge clk); ovf_clr = 1;
    @(negedge clk); ovf_clr = 0;
    chk(!ovf_flag && drop_cnt == 0, "R8 clear", {ovf_flag, drop_cnt}, 0);
    // R8 clear wins over a same-cycle drop
    send(DEPTH, 500, 0);
    @(negedge clk); s_valid = 1; s_data = 999; ovf_clr = 1;
    @(negedge clk); s_valid = 0; ovf_clr = 0;
    chk(!ovf_flag && drop_cnt == 0, "R8 clear priority", {ovf_flag, drop_cnt}, 0);
    drain(500, 0);
    drain(500 + PAY, 0);
    // R2 R9 overlapping fill and drain
    fork
      send(6 * PAY, 1000, 2);
      for (int p = 0; p < 6; p++) drain(1000 + p * PAY, 1);
    join
    repeat (4) @(negedge clk);
    chk(!m_valid && drop_cnt == 0, "R9 no drops while draining", {m_valid, drop_cnt}, 0);
    report();
  end
endmodule